// File: doc/BRIEF.md
# SD Command Line Engine

This block is the host side of the SD bus command line. A single start pulse hands it a 6-bit command index, a 32-bit argument and a response kind. It serialises the 48-bit command frame MSB first, generates the CRC7 bit by bit as the frame is shifted out, and then listens on the command line for the card's reply. The bit clock comes from an enable that fires once every `CLK_DIV` system clocks. The block drives the bus clock from the same divider, so a card model or a real card sees one bit per bus clock.

A reply is captured from its first 0 bit, once the turnaround after the command end bit has passed. Four response kinds are supported:
- **none**: the command completes as soon as its end bit has gone out.
- **short checked**: the CRC7 and the echoed index are verified. Index 41 is exempt from the echo check.
- **short unchecked**: used for operating-condition replies. Neither the CRC nor the index is checked.
- **long**: the leading code byte and a CRC7 over 15 payload bytes are verified.

When no reply starts within the timeout window, the block reports a timeout and becomes idle again. Completion is flagged by a one-cycle `done` pulse. At that point `status` and `resp_data` hold the result.

Top module: `sd_cmd_engine`

## Requirements
- R1: The command frame is 48 bits sent MSB first, one bit per bus clock: 0, then 1, then the 6-bit index, then the 32-bit argument (high bit first), then the 7-bit CRC, then a closing 1. `cmd_oe` is high for exactly those 48 bits.
- R2: The frame CRC7 (polynomial x^7+x^3+1, starting from zero) covers the first 40 frame bits. For index 0 with argument 0 the last byte is 0x95.
- R3: With `resp_kind`=1 (short checked), the block captures a 48-bit reply. When its CRC and its index are correct, `status`=0 (OK) and `resp_data[31:0]` holds reply bits 39..8.
- R4: For a short checked reply, the CRC7 is taken over reply bits 47..8 and compared with bits 7..1. A mismatch gives `status`=2 (CRC error). The CRC is checked before the index.
- R5: For a short checked reply, if bits 45..40 differ from the issued index, `status`=3 (code error). This check is skipped when the issued index is 41.
- R6: With `resp_kind`=2 (short unchecked), the reply is always accepted with `status`=0. `resp_data[31:0]` holds bits 39..8.
- R7: With `resp_kind`=3 (long), the block captures 136 bits. The CRC7 over bits 127..8 must equal bits 7..1, otherwise `status`=2. Bits 135..128 must be 0x3F, otherwise `status`=3. When both hold, `status`=0 and `resp_data[119:0]` holds bits 127..8.
- R8: With `resp_kind`=0 (none), the command completes with `status`=0 right after the end bit.
- R9: If no 0 is sampled within `TIMEOUT_BITS` bus clocks after the end bit, `status`=1 (timeout) and the block returns to idle. A start bit on the last sample of that window is still accepted.
- R10: The first `TURNAROUND` samples after the end bit are ignored, even when they are 0.
- R11: `start` is ignored while `busy` is high. The frame in flight and its checks are not affected.
- R12: `busy` rises the cycle after an accepted `start` and stays high until completion. `done` is a one-cycle pulse, coincident with `busy` falling. `status` stays stable while the block is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start pulse, accepted only while idle |
| cmd_idx | input | 6 | Command index |
| cmd_arg | input | 32 | Command argument |
| resp_kind | input | 2 | 0 none, 1 short checked, 2 short unchecked, 3 long |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| status | output | 2 | 0 OK, 1 timeout, 2 CRC error, 3 code error |
| resp_data | output | 120 | Captured response payload |
| sd_clk | output | 1 | Bus clock |
| cmd_out | output | 1 | Command line drive value |
| cmd_oe | output | 1 | Command line drive enable |
| cmd_in | input | 1 | Command line sampled value |

## Verification
The assertions take for granted that `cmd_in` holds 1 while the card is not replying, and that changes on it land away from the bus clock's falling edge, where the block samples. The bench card model meets both conditions:
- It changes `cmd_in` one time unit after each falling edge of `sd_clk`.
- It releases `cmd_in` to 1 after every reply.

The assertions also take for granted that `start` is held for a single cycle. The bench only raises `start` for one cycle, including the pulse sent deliberately while the block is busy.

// File: rtl/sd_cmd_engine.sv
module sd_cmd_engine #(
  parameter int CLK_DIV      = 4,
  parameter int TIMEOUT_BITS = 800,
  parameter int TURNAROUND   = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [5:0]   cmd_idx,
  input  logic [31:0]  cmd_arg,
  input  logic [1:0]   resp_kind,
  output logic         busy,
  output logic         done,
  output logic [1:0]   status,
  output logic [119:0] resp_data,
  output logic         sd_clk,
  output logic         cmd_out,
  output logic         cmd_oe,
  input  logic         cmd_in
);
  localparam int DW = (CLK_DIV > 2) ? $clog2(CLK_DIV) : 1;
  localparam int TW = $clog2(TIMEOUT_BITS + 1);
  localparam logic [DW-1:0] DIV_LAST = DW'(CLK_DIV - 1);
  localparam logic [DW-1:0] DIV_HALF = DW'(CLK_DIV / 2);
  localparam logic [1:0] K_NONE = 2'd0, K_SHORT = 2'd1, K_RAW = 2'd2, K_LONG = 2'd3;
  localparam logic [1:0] ST_OK = 2'd0, ST_TMO = 2'd1, ST_CRC = 2'd2, ST_CODE = 2'd3;

  typedef enum logic [2:0] {S_IDLE, S_ALIGN, S_SEND, S_WAIT, S_RECV} state_t;
  state_t state;

  logic [DW-1:0]  div_cnt;
  logic [TW-1:0]  wait_cnt;
  logic [7:0]     cnt;
  logic [6:0]     crc, crc_nx;
  logic [47:0]    tx_sr;
  logic [135:0]   rx_sr, rx_full;
  logic [1:0]     kind_q;
  logic [5:0]     idx_q;
  logic           tick, crc_bit, crc_en, is_long, crc_ok;
  logic [1:0]     eval_st;

  assign tick    = (div_cnt == DIV_LAST);
  assign sd_clk  = (div_cnt >= DIV_HALF);
  assign busy    = (state != S_IDLE);
  assign cmd_oe  = (state == S_SEND);
  assign cmd_out = cmd_oe ? tx_sr[47] : 1'b1;
  assign is_long = (kind_q == K_LONG);
  assign rx_full = {rx_sr[134:0], cmd_in};

  assign crc_bit = (state == S_SEND) ? tx_sr[47] : cmd_in;
  assign crc_en  = (state == S_SEND) ? (cnt < 8'd40)
                 : is_long ? (cnt >= 8'd8 && cnt < 8'd128) : (cnt < 8'd40);
  assign crc_nx  = !crc_en ? crc
                 : ({crc[5:0], 1'b0} ^ ((crc[6] ^ crc_bit) ? 7'h09 : 7'h00));
  assign crc_ok  = (crc == rx_full[7:1]);

  always_comb begin
    eval_st = ST_OK;
    if (kind_q == K_SHORT) begin
      if (!crc_ok) eval_st = ST_CRC;
      else if (rx_full[45:40] != idx_q && idx_q != 6'd41) eval_st = ST_CODE;
    end else if (kind_q == K_LONG) begin
      if (!crc_ok) eval_st = ST_CRC;
      else if (rx_full[135:128] != 8'h3F) eval_st = ST_CODE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div_cnt <= '0;
    else        div_cnt <= tick ? '0 : div_cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE;  done <= 1'b0;  status <= ST_OK;  resp_data <= '0;
      cnt <= '0;  wait_cnt <= '0;  crc <= '0;  tx_sr <= '0;  rx_sr <= '0;
      kind_q <= K_NONE;  idx_q <= '0;
    end else begin
      done <= 1'b0;
      case (state)
        S_IDLE: if (start) begin
          state  <= S_ALIGN;
          kind_q <= resp_kind;
          idx_q  <= cmd_idx;
          tx_sr  <= {2'b01, cmd_idx, cmd_arg, 8'h01};
          cnt    <= '0;
          crc    <= '0;
        end
        S_ALIGN: if (tick) state <= S_SEND;
        S_SEND: if (tick) begin
          crc   <= crc_nx;
          tx_sr <= (cnt == 8'd39) ? {crc_nx, 1'b1, 40'b0} : {tx_sr[46:0], 1'b0};
          cnt   <= cnt + 1'b1;
          if (cnt == 8'd47) begin
            wait_cnt <= '0;
            if (kind_q == K_NONE) begin
              state <= S_IDLE;  done <= 1'b1;  status <= ST_OK;
            end else state <= S_WAIT;
          end
        end
        S_WAIT: if (tick) begin
          if (wait_cnt >= TW'(TURNAROUND) && !cmd_in) begin
            state <= S_RECV;  cnt <= 8'd1;  crc <= '0;  rx_sr <= '0;
          end else if (wait_cnt == TW'(TIMEOUT_BITS - 1)) begin
            state <= S_IDLE;  done <= 1'b1;  status <= ST_TMO;
          end else wait_cnt <= wait_cnt + 1'b1;
        end
        S_RECV: if (tick) begin
          crc   <= crc_nx;
          rx_sr <= rx_full;
          cnt   <= cnt + 1'b1;
          if (cnt == (is_long ? 8'd135 : 8'd47)) begin
            state     <= S_IDLE;
            done      <= 1'b1;
            status    <= eval_st;
            resp_data <= is_long ? rx_full[127:8] : {88'b0, rx_full[39:8]};
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  a_r12_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r12_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  a_r12_status_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start && !done) |=> $stable(status) || done);
  a_r11_oe_in_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_oe |-> busy && kind_q == $past(kind_q));
  a_r1_frame_len: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cmd_oe) |-> $past(cnt) == 8'd47);
  a_r9_window: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_WAIT) |-> wait_cnt < TW'(TIMEOUT_BITS));
  a_r10_turnaround: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_WAIT && tick && wait_cnt < TW'(TURNAROUND)) |=> state != S_RECV);
endmodule

// File: tb/test_sd_cmd_engine.sv
module test_sd_cmd_engine;
  logic clk = 0, rst_n = 0, start = 0, cmd_in = 1;
  logic [5:0] cmd_idx = 0;
  logic [31:0] cmd_arg = 0;
  logic [1:0] resp_kind = 0;
  logic busy, done, sd_clk, cmd_out, cmd_oe;
  logic [1:0] status;
  logic [119:0] resp_data;
  int checks = 0, errors = 0, cyc = 0;
  logic [47:0] seen;
  logic [1:0] st_g;
  logic [119:0] rd_g;

  localparam int TMO = 800;

  sd_cmd_engine #(.CLK_DIV(4), .TIMEOUT_BITS(TMO), .TURNAROUND(2)) i_sd_cmd_engine (
    .clk(clk), .rst_n(rst_n), .start(start), .cmd_idx(cmd_idx), .cmd_arg(cmd_arg),
    .resp_kind(resp_kind), .busy(busy), .done(done), .status(status),
    .resp_data(resp_data), .sd_clk(sd_clk), .cmd_out(cmd_out), .cmd_oe(cmd_oe),
    .cmd_in(cmd_in));

  always #10 clk = ~clk;

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 200000) begin
      checks++; errors++;
      $display("FAIL watchdog: run hung, actual %0d cycles expected < 200000", cyc);
      finish_run();
    end
  end

  task automatic chk(input string req, input logic [135:0] act, input logic [135:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [6:0] crc7(input logic [127:0] v, input int n);
    logic [6:0] c = 0;
    for (int i = n - 1; i >= 0; i--) begin
      logic fb = c[6] ^ v[i];
      c = {c[5:0], 1'b0} ^ (fb ? 7'h09 : 7'h00);
    end
    return c;
  endfunction

  function automatic logic [47:0] mk_cmd(input logic [5:0] idx, input logic [31:0] arg);
    logic [39:0] top = {2'b01, idx, arg};
    return {top, crc7(top, 40), 1'b1};
  endfunction

  function automatic logic [47:0] mk_short(input logic [5:0] idx, input logic [31:0] pl,
                                           input logic [6:0] flip);
    logic [39:0] top = {2'b00, idx, pl};
    return {top, crc7(top, 40) ^ flip, 1'b1};
  endfunction

  function automatic logic [135:0] mk_long(input logic [7:0] code, input logic [119:0] pl,
                                           input logic [6:0] flip);
    return {code, pl, crc7(pl, 120) ^ flip, 1'b1};
  endfunction

  task automatic host(input logic [5:0] idx, input logic [31:0] arg, input logic [1:0] kind);
    int n = 0;
    @(negedge clk);
    cmd_idx = idx; cmd_arg = arg; resp_kind = kind; start = 1;
    @(negedge clk);
    start = 0;
    chk("R12 busy after start", busy, 1);
    while (!done && n < 20000) begin @(negedge clk); n++; end
    chk("R12 done seen", done, 1);
    st_g = status; rd_g = resp_data;
    @(negedge clk);
    chk("R12 done one cycle", {busy, done}, 2'b00);
  endtask

  task automatic card(input logic [191:0] seq, input int n, input int dly);
    wait (cmd_oe === 1'b1);
    for (int i = 0; i < 48; i++) begin @(posedge sd_clk); seen = {seen[46:0], cmd_out}; end
    @(negedge sd_clk);
    repeat (dly) @(negedge sd_clk);
    for (int i = 0; i < n; i++) begin
      #1 cmd_in = seq[n-1-i];
      @(negedge sd_clk);
    end
    #1 cmd_in = 1;
  endtask

  task automatic run(input logic [5:0] idx, input logic [31:0] arg, input logic [1:0] kind,
                     input logic [191:0] seq, input int n, input int dly);
    fork
      host(idx, arg, kind);
      card(seq, n, dly);
    join
  endtask

  task automatic t_reset();
    chk("R12 reset busy/done/oe/status", {busy, done, cmd_oe, status}, 5'b0);
  endtask

  task automatic t_no_resp();
    run(6'd0, 32'd0, 2'd0, '0, 0, 0);
    chk("R2 CMD0 frame", seen, 48'h40_0000_0000_95);
    chk("R8 no-response status", st_g, 2'd0);
    run(6'd17, 32'h1234_5678, 2'd0, '0, 0, 0);
    chk("R1 frame layout", seen, mk_cmd(6'd17, 32'h1234_5678));
  endtask

  task automatic t_short();
    run(6'd8, 32'h0000_01AA, 2'd1, {144'b0, mk_short(6'd8, 32'h0000_01AA, 7'd0)}, 48, 3);
    chk("R1 frame CMD8", seen, mk_cmd(6'd8, 32'h0000_01AA));
    chk("R3 short OK status", st_g, 2'd0);
    chk("R3 short payload", rd_g, {88'b0, 32'h0000_01AA});
    run(6'd13, 32'h0, 2'd1, {144'b0, mk_short(6'd13, 32'hCAFE_0900, 7'h01)}, 48, 2);
    chk("R4 short crc error", st_g, 2'd2);
    run(6'd13, 32'h0, 2'd1, {144'b0, mk_short(6'd12, 32'hCAFE_0900, 7'h10)}, 48, 2);
    chk("R4 crc before index", st_g, 2'd2);
    run(6'd13, 32'h0, 2'd1, {144'b0, mk_short(6'd12, 32'hCAFE_0900, 7'd0)}, 48, 4);
    chk("R5 index mismatch", st_g, 2'd3);
    run(6'd41, 32'h40FF_8000, 2'd1, {144'b0, mk_short(6'd63, 32'h80FF_8000, 7'd0)}, 48, 2);
    chk("R5 index 41 exempt", st_g, 2'd0);
  endtask

  task automatic t_raw();
    run(6'd41, 32'h0, 2'd2, {144'b0, 2'b00, 6'h3F, 32'hC0FF_8000, 8'hFF}, 48, 5);
    chk("R6 unchecked status", st_g, 2'd0);
    chk("R6 unchecked payload", rd_g, {88'b0, 32'hC0FF_8000});
  endtask

  task automatic t_long();
    logic [119:0] pl = 120'h0123_4567_89AB_CDEF_F0E1_D2C3_B4A5_96;
    run(6'd2, 32'h0, 2'd3, {56'b0, mk_long(8'h3F, pl, 7'd0)}, 136, 2);
    chk("R7 long OK status", st_g, 2'd0);
    chk("R7 long payload", rd_g, pl);
    run(6'd9, 32'h0, 2'd3, {56'b0, mk_long(8'h3E, pl, 7'd0)}, 136, 2);
    chk("R7 long bad code", st_g, 2'd3);
    run(6'd9, 32'h0, 2'd3, {56'b0, mk_long(8'h3F, pl, 7'h40)}, 136, 2);
    chk("R7 long bad crc", st_g, 2'd2);
  endtask

  task automatic t_timeout();
    run(6'd55, 32'h0, 2'd1, '0, 0, 0);
    chk("R9 timeout status", st_g, 2'd1);
    run(6'd16, 32'h200, 2'd1, {144'b0, mk_short(6'd16, 32'h0000_0900, 7'd0)}, 48, TMO - 1);
    chk("R9 start on last sample", st_g, 2'd0);
    run(6'd16, 32'h200, 2'd1, {144'b0, mk_short(6'd16, 32'h0000_0900, 7'd0)}, 48, TMO);
    chk("R9 start one past window", st_g, 2'd1);
  endtask

  task automatic t_turnaround();
    run(6'd7, 32'h0, 2'd1, {139'b0, 5'b00111, mk_short(6'd7, 32'h1111_2222, 7'd0)}, 53, 0);
    chk("R10 early zeros ignored", st_g, 2'd0);
    chk("R10 payload after turnaround", rd_g, {88'b0, 32'h1111_2222});
  endtask

  task automatic t_busy_start();
    fork
      run(6'd3, 32'hA5A5_0000, 2'd1, {144'b0, mk_short(6'd3, 32'h0BAD_0000, 7'd0)}, 48, 2);
      begin
        repeat (40) @(negedge clk);
        cmd_idx = 6'd9; cmd_arg = 32'hFFFF_FFFF; resp_kind = 2'd0; start = 1;
        @(negedge clk); start = 0;
      end
    join
    chk("R11 frame unaffected", seen, mk_cmd(6'd3, 32'hA5A5_0000));
    chk("R11 checks unaffected", st_g, 2'd0);
    repeat (20) @(negedge clk);
    chk("R12 status stable idle", {busy, status}, 3'b000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    repeat (2) @(negedge clk);
    t_no_resp();
    t_short();
    t_raw();
    t_long();
    t_timeout();
    t_turnaround();
    t_busy_start();
    finish_run();
  end
endmodule